// File: doc/BRIEF.md
# Array Average Compute Unit

This block computes the unsigned integer average of the first N words of a small array. A three-state controller with one flip-flop per state sequences a datapath. The datapath holds an accumulator, an address counter, a two-function ALU (add or divide), and a multiplexer that picks the ALU's second operand. That operand is either the array word at the current address or N itself. The array sits outside the block and is read through a combinational port: the block presents an address, and the word at that address is expected back in the same cycle.

The controller runs continuously. The clear state leads to a summing pass, the summing pass leads to a single divide step, and the divide step leads back to the clear state. A one-cycle start pulse forces the controller back into the clear state from anywhere, which restarts the pass. At the end of every pass the truncated quotient is captured in a result register, and a one-cycle done strobe is raised alongside it.

Top module: `avg_unit`

## Requirements
- R1: The controller holds exactly one of three state bits (clear, sum, divide) at all times. A synchronous active-high reset puts it in the clear state and zeroes the accumulator, the address, `result` and `done`.
- R2: A `start` pulse sampled at a clock edge puts the controller in the clear state for the following cycle, whatever the current state. This overrides every other transition and restarts the pass.
- R3: The clear state is always followed by the sum state. While the address is below `n`, each sum cycle adds the word on `mem_data` to the accumulator and increments the address. The address is driven on `mem_addr` and starts from 0 in the first sum cycle.
- R4: When the address in the sum state is greater than or equal to `n`, no word is added and the next state is the divide state. The divide state always returns to the clear state, so one pass lasts N+3 cycles.
- R5: The accumulator is zeroed in every clear-state cycle, so repeated passes over the same data give the same result rather than a running total.
- R6: The 2-bit ALU opcode is 00 for add and 11 for divide, and both bits follow the divide state bit. In the divide state the ALU's second operand is `n`; otherwise it is `mem_data`.
- R7: `result` holds the truncated unsigned quotient of the 32-bit (wrapping) sum divided by `n`. It updates together with a one-cycle `done` pulse N+3 clock edges after the edge that samples `start`, and `done` is low in the cycles before that edge.
- R8: With `n` = 0, no word is summed, `result` becomes 0 with no divide-by-zero, and `done` rises 3 edges after `start` is sampled.
- R9: With no new `start`, the unit repeats the pass and raises `done` again every N+3 cycles with the same result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle restart pulse |
| n | input | 32 | Number of words to average |
| mem_data | input | 32 | Array word at `mem_addr`, returned in the same cycle |
| mem_addr | output | 8 | Current array address (registered) |
| result | output | 32 | Registered average of the last completed pass |
| done | output | 1 | One-cycle strobe marking a new `result` |

## Verification
The assertions assume that `n` and the array contents stay unchanged from the `start` pulse until the matching `done`. They also assume that `mem_data` follows `mem_addr` combinationally, and that `start` lasts a single cycle. The stimulus keeps to these conditions: it loads the array and `n` before the pulse, holds them through the pass, and models the array as a lookup indexed by `mem_addr`. Every N it uses is no larger than the modelled array.

// File: rtl/avg_pkg.sv
package avg_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_DIV = 2'b11
  } alu_op_e;

  localparam int ST_CLR = 0;
  localparam int ST_SUM = 1;
  localparam int ST_DIV = 2;
  localparam int ST_NUM = 3;
endpackage

// File: rtl/avg_ctrl.sv
module avg_ctrl
  import avg_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    addr_lt_n,
  output logic    acc_clr,
  output logic    summing,
  output logic    opnd_sel,
  output alu_op_e alu_op
);
  logic [ST_NUM-1:0] st_q, st_d;

  always_comb begin
    st_d = '0;
    if (start) begin
      st_d[ST_CLR] = 1'b1;
    end else begin
      st_d[ST_CLR] = st_q[ST_DIV];
      st_d[ST_SUM] = st_q[ST_CLR] | (st_q[ST_SUM] & addr_lt_n);
      st_d[ST_DIV] = st_q[ST_SUM] & ~addr_lt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_NUM'(1) << ST_CLR;
    else     st_q <= st_d;
  end

  assign acc_clr  = st_q[ST_CLR];
  assign summing  = st_q[ST_SUM];
  assign opnd_sel = st_q[ST_DIV];
  assign alu_op   = alu_op_e'({2{st_q[ST_DIV]}});

  assert_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $countones(st_q) == 1);
  assert_start_clear_R2: assert property (@(posedge clk) disable iff (rst)
    start |=> st_q[ST_CLR]);
  assert_clear_to_sum_R3: assert property (@(posedge clk) disable iff (rst)
    (st_q[ST_CLR] && !start) |=> st_q[ST_SUM]);
  assert_div_to_clear_R4: assert property (@(posedge clk) disable iff (rst)
    st_q[ST_DIV] |=> st_q[ST_CLR]);
  assert_sum_exit_R4: assert property (@(posedge clk) disable iff (rst)
    (st_q[ST_SUM] && !addr_lt_n && !start) |=> st_q[ST_DIV]);
  assert_opcode_R6: assert property (@(posedge clk) disable iff (rst)
    (alu_op == OP_DIV) == opnd_sel);
endmodule

// File: rtl/avg_alu.sv
module avg_alu
  import avg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_DIV:  y = (b == '0) ? '0 : a / b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/avg_datapath.sv
module avg_datapath
  import avg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_clr,
  input  logic              summing,
  input  logic              opnd_sel,
  input  alu_op_e           alu_op,
  input  logic [DATA_W-1:0] n,
  input  logic [DATA_W-1:0] mem_data,
  output logic              addr_lt_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] result,
  output logic              done
);
  logic [DATA_W-1:0] acc_q, addr_q, res_q, opnd_b, alu_y;
  logic              done_q;

  assign addr_lt_n = addr_q < n;
  assign opnd_b    = opnd_sel ? n : mem_data;

  avg_alu #(.DATA_W(DATA_W)) u_alu (
    .op (alu_op),
    .a  (acc_q),
    .b  (opnd_b),
    .y  (alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      addr_q <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= opnd_sel;
      if (opnd_sel) res_q <= alu_y;
      if (acc_clr) begin
        acc_q  <= '0;
        addr_q <= '0;
      end else if (summing && addr_lt_n) begin
        acc_q  <= alu_y;
        addr_q <= addr_q + 1'b1;
      end
    end
  end

  assign mem_addr = addr_q[ADDR_W-1:0];
  assign result   = res_q;
  assign done     = done_q;

  assert_acc_clear_R5: assert property (@(posedge clk) disable iff (rst)
    acc_clr |=> (acc_q == '0 && addr_q == '0));
  assert_addr_step_R3: assert property (@(posedge clk) disable iff (rst)
    (summing && addr_lt_n) |=> addr_q == $past(addr_q) + 1'b1);
  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_zero_n_R8: assert property (@(posedge clk) disable iff (rst)
    (opnd_sel && n == '0) |=> result == '0);
endmodule

// File: rtl/avg_unit.sv
module avg_unit
  import avg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] n,
  input  logic [DATA_W-1:0] mem_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] result,
  output logic              done
);
  logic    acc_clr, summing, opnd_sel, addr_lt_n;
  alu_op_e alu_op;

  avg_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .addr_lt_n (addr_lt_n),
    .acc_clr   (acc_clr),
    .summing   (summing),
    .opnd_sel  (opnd_sel),
    .alu_op    (alu_op)
  );

  avg_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .acc_clr   (acc_clr),
    .summing   (summing),
    .opnd_sel  (opnd_sel),
    .alu_op    (alu_op),
    .n         (n),
    .mem_data  (mem_data),
    .addr_lt_n (addr_lt_n),
    .mem_addr  (mem_addr),
    .result    (result),
    .done      (done)
  );
endmodule

// File: tb/tb_avg_unit.sv
module tb_avg_unit;
  localparam int CLK_P = 10;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int DEPTH = 16;
  localparam int NVEC = 5;
  // each row: N, first word, step between words
  localparam logic [31:0] VEC [NVEC][3] = '{
    '{32'd4,  32'd10,          32'd1},
    '{32'd1,  32'd7,           32'd0},
    '{32'd16, 32'd3,           32'd5},
    '{32'd3,  32'hFFFF_FFF0,   32'd9},
    '{32'd7,  32'd1000,        32'd13}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [DW-1:0] n = '0;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] mem_data;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] result;
  logic          done;
  int checks = 0;
  int fails = 0;

  always #(CLK_P/2) clk = ~clk;
  assign mem_data = mem[mem_addr[3:0]];

  avg_unit #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .start(start), .n(n),
    .mem_data(mem_data), .mem_addr(mem_addr),
    .result(result), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [31:0] base, input logic [31:0] step);
    for (int i = 0; i < DEPTH; i++) mem[i] = base + step * i;
  endtask

  function automatic logic [31:0] expect_avg(input logic [31:0] cnt);
    logic [31:0] s = 0;
    for (int i = 0; i < int'(cnt); i++) s = s + mem[i];
    return (cnt == 0) ? 32'd0 : s / cnt;
  endfunction

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // waits a whole pass after start; done must be low until edge N+3
  task automatic check_pass(input string req, input logic [31:0] exp);
    repeat (int'(n) + 2) begin
      @(negedge clk);
      chk({req, " done early"}, {31'd0, done}, 32'd0);
    end
    @(negedge clk);
    chk({req, " done"}, {31'd0, done}, 32'd1);
    chk({req, " result"}, result, exp);
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    fill(32'd0, 32'd0);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 result", result, 32'd0);
    chk("R1 addr", {24'd0, mem_addr}, 32'd0);
    rst = 1'b0;

    for (int v = 0; v < NVEC; v++) begin
      fill(VEC[v][1], VEC[v][2]);
      n = VEC[v][0];
      pulse_start();
      // R3 address begins at 0 in first sum cycle, then steps
      @(negedge clk);
      chk("R3 addr0", {24'd0, mem_addr}, 32'd0);
      @(negedge clk);
      chk("R3 addr1", {24'd0, mem_addr}, 32'd1);
      repeat (int'(n)) begin
        @(negedge clk);
        chk("R7 done early", {31'd0, done}, 32'd0);
      end
      @(negedge clk);
      chk("R7 R6 done", {31'd0, done}, 32'd1);
      chk("R7 R6 result", result, expect_avg(n));
    end

    // R9 and R5: free-running repeat gives same result, not a running total
    fill(32'd20, 32'd4);
    n = 32'd5;
    pulse_start();
    check_pass("R9 first", expect_avg(n));
    check_pass("R5 R4 repeat", expect_avg(n));

    // R8: n = 0
    n = 32'd0;
    pulse_start();
    check_pass("R8", 32'd0);

    // R2: restart in the middle of a sum pass
    fill(32'd50, 32'd2);
    n = 32'd6;
    pulse_start();
    repeat (3) @(negedge clk);
    pulse_start();
    check_pass("R2 restart", expect_avg(n));

    // R1: reset in the middle of a pass
    pulse_start();
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid done", {31'd0, done}, 32'd0);
    chk("R1 mid result", result, 32'd0);
    chk("R1 mid addr", {24'd0, mem_addr}, 32'd0);
    rst = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule